// File: doc/BRIEF.md
# Extension Command Dispatch Unit

This block carries out the eight overloaded extension command instructions of a processor. Each instruction supplies a 3-bit command index, a first operand whose low 12 bits name a logical unit number (LUN), a free second operand and the privilege level of the hart. The unit looks the (LUN, privilege) pair up in a small table. A hit gives a target select and a 12-bit subdevice id. The unit then either answers from its built-in fallback target or raises a request on one of several pluggable device ports. The request carries a 15-bit command code and both operands. The response comes back as the destination value.

A lookup that finds no valid entry, or that names LUN 0, ends in an illegal-instruction trap and produces no device request. A device that does not implement the command code it receives answers with a configuration-error flag, and the unit turns that into a trap with a different cause. The table is loaded through a write port, one entry per write, and each entry has its own valid bit. External devices may take any number of cycles, because they answer with a request/acknowledge handshake.

Top module: `ext_cmd_dispatch`

## Requirements
- R1: After reset `op_ready` is 1, `dev_req` is all zero, `done` is 0, and every table entry is invalid, so any command traps.
- R2: The LUN is `op_rs1[11:0]`. The complete `op_rs1` and `op_rs2` values of the accepted command appear unchanged on `dev_rs1` and `dev_rs2` while the request is raised.
- R3: A command hits an entry only if the entry is valid and both its LUN and its privilege match. Privilege is encoded as 0 user, 1 supervisor, 2 hypervisor, 3 machine. One LUN may lead to different targets at different privileges, or to none. When several entries match, the lowest entry index wins.
- R4: A command with LUN 0, or one that hits no entry, gives `done`=1 with `trap`=1 and `trap_cause`=0 (illegal instruction) in the cycle after it is accepted, and raises no `dev_req`.
- R5: `dev_code` equals the subdevice id in bits [11:0] with the command index in bits [14:12].
- R6: Target select 0 is the built-in fallback. It answers in the cycle after acceptance, with no device request. Subdevice 0 gives `rd`=0 and subdevice 1 gives `rd`=all ones. Any other subdevice gives `trap`=1 with `trap_cause`=1.
- R7: Target select s (s ≥ 1) raises `dev_req[s-1]` alone and holds it, with code and operands stable, until `dev_ack[s-1]` is high. One cycle after that acknowledge, `done`=1 and `rd` equals that port's `dev_rdata` slice. Acknowledges on other ports are ignored.
- R8: If `dev_cfg_err` of the selected port is high together with its acknowledge, the result is `trap`=1 with `trap_cause`=1 (configuration error).
- R9: `op_ready` is 0 while a device request is outstanding, and `op_valid` in that time is ignored.
- R10: A write with `cfg_we`=1 replaces entry `cfg_idx` at the clock edge. Writing `cfg_valid`=0 removes the entry from all lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Entry index written |
| cfg_valid | input | 1 | Valid bit of the written entry |
| cfg_lun | input | 12 | LUN of the written entry |
| cfg_priv | input | 2 | Privilege of the written entry |
| cfg_sel | input | SEL_W | Target select: 0 fallback, s for port s-1 |
| cfg_sub | input | 12 | Subdevice id of the written entry |
| op_valid | input | 1 | Command present |
| op_ready | output | 1 | Unit can accept a command |
| op_idx | input | 3 | Command index k |
| op_rs1 | input | XLEN | First operand, LUN in [11:0] |
| op_rs2 | input | XLEN | Second operand |
| op_priv | input | 2 | Current privilege |
| dev_req | output | NDEV | Request, one bit per device port |
| dev_code | output | 15 | Command code {k, subdevice} |
| dev_rs1 | output | XLEN | Forwarded first operand |
| dev_rs2 | output | XLEN | Forwarded second operand |
| dev_ack | input | NDEV | Acknowledge per port |
| dev_rdata | input | NDEV*XLEN | Response data, port i in slice i |
| dev_cfg_err | input | NDEV | Unsupported-code flag, valid with acknowledge |
| done | output | 1 | One-cycle completion pulse |
| rd | output | XLEN | Result value |
| trap | output | 1 | Completion is a trap |
| trap_cause | output | 1 | 0 illegal instruction, 1 configuration error |

## Verification
A wrong table entry or a broken match shows up one cycle after acceptance. It appears either as a trap where a result was due, or as a request on the wrong port or with the wrong code. A lost wait state shows up as a `done` that comes before the acknowledge, or as a request that drops or changes while no acknowledge has come. A stale result register shows up as a wrong `rd` in the single completion cycle, or as a second `done` pulse in the cycle after it.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
    localparam int LUN_W  = 12;
    localparam int SUB_W  = 12;
    localparam int KIDX_W = 3;
    localparam int PRIV_W = 2;
    localparam int CODE_W = SUB_W + KIDX_W;

    localparam logic CAUSE_ILLEGAL = 1'b0;
    localparam logic CAUSE_CONFIG  = 1'b1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } disp_state_e;
endpackage

// File: rtl/lun_table.sv
module lun_table
    import dispatch_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int SEL_W   = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [LUN_W-1:0]  wr_lun,
    input  logic [PRIV_W-1:0] wr_priv,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [SUB_W-1:0]  wr_sub,
    input  logic [LUN_W-1:0]  key_lun,
    input  logic [PRIV_W-1:0] key_priv,
    output logic              hit,
    output logic [SEL_W-1:0]  hit_sel,
    output logic [SUB_W-1:0]  hit_sub
);
    typedef struct packed {
        logic              vld;
        logic [LUN_W-1:0]  lun;
        logic [PRIV_W-1:0] priv;
        logic [SEL_W-1:0]  sel;
        logic [SUB_W-1:0]  sub;
    } slot_t;

    slot_t slot_q [ENTRIES];
    slot_t slot_d [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            slot_d[wr_idx] = '{vld: wr_valid, lun: wr_lun, priv: wr_priv,
                               sel: wr_sel, sub: wr_sub};
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = slot_q[g].vld && (slot_q[g].lun == key_lun)
                          && (slot_q[g].priv == key_priv);
    end

    // scan downward so the lowest matching index is the last one written
    always_comb begin
        hit     = 1'b0;
        hit_sel = '0;
        hit_sub = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_sel = slot_q[i].sel;
                hit_sub = slot_q[i].sub;
            end
        end
    end
endmodule

// File: rtl/fallback_target.sv
module fallback_target
    import dispatch_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [SUB_W-1:0] sub,
    output logic [XLEN-1:0]  value,
    output logic             unsupported
);
    always_comb begin
        value       = '0;
        unsupported = 1'b0;
        case (sub)
            SUB_W'(0): value = '0;
            SUB_W'(1): value = '1;
            default:   unsupported = 1'b1;
        endcase
    end
endmodule

// File: rtl/resp_select.sv
module resp_select #(
    parameter int XLEN  = 32,
    parameter int NDEV  = 2,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic [NDEV-1:0]      ack,
    input  logic [NDEV*XLEN-1:0] rdata,
    input  logic [NDEV-1:0]      cfg_err,
    output logic                 got,
    output logic [XLEN-1:0]      data,
    output logic                 err
);
    always_comb begin
        got  = 1'b0;
        data = '0;
        err  = 1'b0;
        for (int i = 0; i < NDEV; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                got  = ack[i];
                data = rdata[i*XLEN +: XLEN];
                err  = cfg_err[i];
            end
        end
    end
endmodule

// File: rtl/ext_cmd_dispatch.sv
module ext_cmd_dispatch
    import dispatch_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NDEV    = 2,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int SEL_W  = $clog2(NDEV + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_valid,
    input  logic [LUN_W-1:0]     cfg_lun,
    input  logic [PRIV_W-1:0]    cfg_priv,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [SUB_W-1:0]     cfg_sub,
    input  logic                 op_valid,
    output logic                 op_ready,
    input  logic [KIDX_W-1:0]    op_idx,
    input  logic [XLEN-1:0]      op_rs1,
    input  logic [XLEN-1:0]      op_rs2,
    input  logic [PRIV_W-1:0]    op_priv,
    output logic [NDEV-1:0]      dev_req,
    output logic [CODE_W-1:0]    dev_code,
    output logic [XLEN-1:0]      dev_rs1,
    output logic [XLEN-1:0]      dev_rs2,
    input  logic [NDEV-1:0]      dev_ack,
    input  logic [NDEV*XLEN-1:0] dev_rdata,
    input  logic [NDEV-1:0]      dev_cfg_err,
    output logic                 done,
    output logic [XLEN-1:0]      rd,
    output logic                 trap,
    output logic                 trap_cause
);
    typedef struct packed {
        disp_state_e         st;
        logic [SEL_W-1:0]    sel;
        logic [CODE_W-1:0]   code;
        logic [XLEN-1:0]     rs1;
        logic [XLEN-1:0]     rs2;
        logic                done;
        logic [XLEN-1:0]     rd;
        logic                trap;
        logic                cause;
    } disp_regs_t;

    disp_regs_t r_q, r_d;

    logic [LUN_W-1:0] key_lun;
    logic             tab_hit;
    logic [SEL_W-1:0] tab_sel;
    logic [SUB_W-1:0] tab_sub;
    logic [XLEN-1:0]  fb_value;
    logic             fb_bad;
    logic             rsp_got;
    logic [XLEN-1:0]  rsp_data;
    logic             rsp_err;

    assign key_lun = op_rs1[LUN_W-1:0];

    lun_table #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_valid (cfg_valid),
        .wr_lun   (cfg_lun),
        .wr_priv  (cfg_priv),
        .wr_sel   (cfg_sel),
        .wr_sub   (cfg_sub),
        .key_lun  (key_lun),
        .key_priv (op_priv),
        .hit      (tab_hit),
        .hit_sel  (tab_sel),
        .hit_sub  (tab_sub)
    );

    fallback_target #(.XLEN(XLEN)) u_fallback (
        .sub         (tab_sub),
        .value       (fb_value),
        .unsupported (fb_bad)
    );

    resp_select #(.XLEN(XLEN), .NDEV(NDEV), .SEL_W(SEL_W)) u_resp (
        .sel     (r_q.sel),
        .ack     (dev_ack),
        .rdata   (dev_rdata),
        .cfg_err (dev_cfg_err),
        .got     (rsp_got),
        .data    (rsp_data),
        .err     (rsp_err)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.trap  = 1'b0;
        r_d.cause = CAUSE_ILLEGAL;
        case (r_q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    if (key_lun == '0 || !tab_hit) begin
                        r_d.done  = 1'b1;
                        r_d.trap  = 1'b1;
                        r_d.cause = CAUSE_ILLEGAL;
                        r_d.rd    = '0;
                    end else if (tab_sel == '0) begin
                        r_d.done  = 1'b1;
                        r_d.trap  = fb_bad;
                        r_d.cause = fb_bad ? CAUSE_CONFIG : CAUSE_ILLEGAL;
                        r_d.rd    = fb_bad ? '0 : fb_value;
                    end else begin
                        r_d.st   = ST_WAIT;
                        r_d.sel  = tab_sel;
                        r_d.code = {op_idx, tab_sub};
                        r_d.rs1  = op_rs1;
                        r_d.rs2  = op_rs2;
                    end
                end
            end
            ST_WAIT: begin
                if (rsp_got) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.trap  = rsp_err;
                    r_d.cause = rsp_err ? CAUSE_CONFIG : CAUSE_ILLEGAL;
                    r_d.rd    = rsp_err ? '0 : rsp_data;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NDEV; g++) begin : g_req
        assign dev_req[g] = (r_q.st == ST_WAIT) && (r_q.sel == SEL_W'(g + 1));
    end

    assign op_ready   = (r_q.st == ST_IDLE);
    assign dev_code   = r_q.code;
    assign dev_rs1    = r_q.rs1;
    assign dev_rs2    = r_q.rs2;
    assign done       = r_q.done;
    assign rd         = r_q.rd;
    assign trap       = r_q.trap;
    assign trap_cause = r_q.cause;
endmodule

// File: rtl/ext_cmd_dispatch_chk.sv
module ext_cmd_dispatch_chk #(
    parameter int XLEN = 32,
    parameter int NDEV = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic [2:0]        op_idx,
    input logic [XLEN-1:0]   op_rs1,
    input logic [XLEN-1:0]   op_rs2,
    input logic [NDEV-1:0]   dev_req,
    input logic [NDEV-1:0]   dev_ack,
    input logic [14:0]       dev_code,
    input logic [XLEN-1:0]   dev_rs1,
    input logic [XLEN-1:0]   dev_rs2,
    input logic              done,
    input logic              trap,
    input logic              trap_cause
);
    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_req)); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dev_req) && !(|(dev_req & dev_ack)))
        |=> (dev_req == $past(dev_req)) && $stable(dev_code)
            && $stable(dev_rs1) && $stable(dev_rs2)); // R7

    AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dev_req & dev_ack)) |=> done && (dev_req == '0)); // R7

    AST_CODE_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dev_req) |-> (dev_code[14:12] == $past(op_idx))
            && (dev_rs1 == $past(op_rs1)) && (dev_rs2 == $past(op_rs2))); // R5

    AST_LUN0_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && (op_rs1[11:0] == 12'd0))
        |=> done && trap && !trap_cause && (dev_req == '0)); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_req) |-> !op_ready); // R9

    AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> done); // R4
endmodule

bind ext_cmd_dispatch ext_cmd_dispatch_chk #(.XLEN(XLEN), .NDEV(NDEV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_idx     (op_idx),
    .op_rs1     (op_rs1),
    .op_rs2     (op_rs2),
    .dev_req    (dev_req),
    .dev_ack    (dev_ack),
    .dev_code   (dev_code),
    .dev_rs1    (dev_rs1),
    .dev_rs2    (dev_rs2),
    .done       (done),
    .trap       (trap),
    .trap_cause (trap_cause)
);

// File: tb/tb_ext_cmd_dispatch.sv
module tb_ext_cmd_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int NDEV = 2;
    localparam int ENTRIES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic cfg_valid = 1'b0;
    logic [11:0] cfg_lun = '0;
    logic [1:0] cfg_priv = '0;
    logic [1:0] cfg_sel = '0;
    logic [11:0] cfg_sub = '0;
    logic op_valid = 1'b0;
    logic op_ready;
    logic [2:0] op_idx = '0;
    logic [XLEN-1:0] op_rs1 = '0;
    logic [XLEN-1:0] op_rs2 = '0;
    logic [1:0] op_priv = '0;
    logic [NDEV-1:0] dev_req;
    logic [14:0] dev_code;
    logic [XLEN-1:0] dev_rs1, dev_rs2;
    logic [NDEV-1:0] dev_ack = '0;
    logic [NDEV*XLEN-1:0] dev_rdata = '0;
    logic [NDEV-1:0] dev_cfg_err = '0;
    logic done;
    logic [XLEN-1:0] rd;
    logic trap, trap_cause;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_cmd_dispatch #(.XLEN(XLEN), .NDEV(NDEV), .ENTRIES(ENTRIES)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_lun(cfg_lun),
        .cfg_priv(cfg_priv), .cfg_sel(cfg_sel), .cfg_sub(cfg_sub),
        .op_valid(op_valid), .op_ready(op_ready), .op_idx(op_idx), .op_rs1(op_rs1),
        .op_rs2(op_rs2), .op_priv(op_priv),
        .dev_req(dev_req), .dev_code(dev_code), .dev_rs1(dev_rs1), .dev_rs2(dev_rs2),
        .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_cfg_err(dev_cfg_err),
        .done(done), .rd(rd), .trap(trap), .trap_cause(trap_cause)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input logic vld, input logic [11:0] lun,
                       input logic [1:0] priv, input logic [1:0] sel, input logic [11:0] sub);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = vld;
        cfg_lun = lun; cfg_priv = priv; cfg_sel = sel; cfg_sub = sub;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // present one command for one cycle; returns at the negedge after acceptance
    task automatic send(input logic [2:0] k, input logic [XLEN-1:0] a,
                        input logic [XLEN-1:0] b, input logic [1:0] priv);
        @(negedge clk);
        op_valid = 1'b1; op_idx = k; op_rs1 = a; op_rs2 = b; op_priv = priv;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_trap(input string tag, input logic cause);
        chk({tag, " done"}, 64'(done), 64'(1));
        chk({tag, " trap"}, 64'(trap), 64'(1));
        chk({tag, " cause"}, 64'(trap_cause), 64'(cause));
        chk({tag, " no req"}, 64'(dev_req), 64'(0));
    endtask

    task automatic ext_op(input string tag, input logic [2:0] k, input logic [XLEN-1:0] a,
                          input logic [XLEN-1:0] b, input logic [1:0] priv, input int port,
                          input logic [14:0] code, input int lat, input logic [XLEN-1:0] data,
                          input logic err);
        send(k, a, b, priv);
        chk({tag, " R7 req port"}, 64'(dev_req), 64'(1 << port));
        chk({tag, " R5 code"}, 64'(dev_code), 64'(code));
        chk({tag, " R2 rs1"}, 64'(dev_rs1), 64'(a));
        chk({tag, " R2 rs2"}, 64'(dev_rs2), 64'(b));
        chk({tag, " R9 not ready"}, 64'(op_ready), 64'(0));
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk({tag, " R7 req held"}, 64'(dev_req), 64'(1 << port));
            chk({tag, " R7 no early done"}, 64'(done), 64'(0));
        end
        dev_rdata[port*XLEN +: XLEN] = data;
        dev_cfg_err[port] = err;
        dev_ack[port] = 1'b1;
        @(negedge clk);
        dev_ack = '0;
        dev_cfg_err = '0;
        chk({tag, " R7 done"}, 64'(done), 64'(1));
        chk({tag, " R8 trap"}, 64'(trap), 64'(err));
        if (err) chk({tag, " R8 cause"}, 64'(trap_cause), 64'(1));
        else     chk({tag, " R7 rd"}, 64'(rd), 64'(data));
        chk({tag, " R7 req dropped"}, 64'(dev_req), 64'(0));
    endtask

    task automatic t_reset;
        chk("R1 ready", 64'(op_ready), 64'(1));
        chk("R1 no req", 64'(dev_req), 64'(0));
        chk("R1 no done", 64'(done), 64'(0));
        send(3'd0, 32'h0000_0001, 32'h0, 2'd0);
        expect_trap("R1 empty table", 1'b0);
    endtask

    task automatic t_load;
        cfg(0, 1'b1, 12'd1,  2'd0, 2'd0, 12'd0);
        cfg(1, 1'b1, 12'd2,  2'd0, 2'd0, 12'd1);
        cfg(2, 1'b1, 12'd3,  2'd0, 2'd0, 12'd5);
        cfg(3, 1'b1, 12'd32, 2'd0, 2'd1, 12'd0);
        cfg(4, 1'b1, 12'd32, 2'd3, 2'd1, 12'd64);
        cfg(5, 1'b1, 12'd33, 2'd1, 2'd2, 12'd1);
        cfg(6, 1'b1, 12'd33, 2'd1, 2'd1, 12'd7);
        cfg(7, 1'b1, 12'd0,  2'd0, 2'd1, 12'd0);
    endtask

    task automatic t_fallback;
        send(3'd4, 32'h1234_5001, 32'hDEAD_BEEF, 2'd0);
        chk("R6 zero done", 64'(done), 64'(1));
        chk("R6 zero trap", 64'(trap), 64'(0));
        chk("R6 zero rd", 64'(rd), 64'(0));
        chk("R6 zero no req", 64'(dev_req), 64'(0));
        send(3'd1, 32'h0000_0002, 32'h0, 2'd0);
        chk("R6 ones done", 64'(done), 64'(1));
        chk("R6 ones trap", 64'(trap), 64'(0));
        chk("R6 ones rd", 64'(rd), 64'hFFFF_FFFF);
        send(3'd0, 32'h0000_0003, 32'h0, 2'd0);
        expect_trap("R6 bad subdevice", 1'b1);
        @(negedge clk);
        chk("R6 single pulse", 64'(done), 64'(0));
    endtask

    task automatic t_lun0;
        send(3'd2, 32'hFFFF_F000, 32'h5, 2'd0);
        expect_trap("R4 lun zero", 1'b0);
    endtask

    task automatic t_priv_miss;
        send(3'd0, 32'h0000_0021, 32'h0, 2'd0);
        expect_trap("R3 absent at user", 1'b0);
        send(3'd0, 32'h0000_0020, 32'h0, 2'd2);
        expect_trap("R4 no entry", 1'b0);
    endtask

    task automatic t_external;
        ext_op("user lun32", 3'd5, 32'hABCD_E020, 32'h1357_9BDF, 2'd0, 0,
               15'h5000, 3, 32'hCAFE_0001, 1'b0);
        ext_op("R3 mach lun32", 3'd2, 32'h0000_0020, 32'h1, 2'd3, 0,
               15'h2040, 0, 32'h0BAD_F00D, 1'b0);
        ext_op("R3 dup lowest", 3'd7, 32'h8000_0021, 32'h2, 2'd1, 1,
               15'h7001, 2, 32'h7654_3210, 1'b0);
    endtask

    task automatic t_other_ack;
        send(3'd1, 32'h0000_0020, 32'h9, 2'd0);
        dev_ack[1] = 1'b1;
        dev_rdata[XLEN +: XLEN] = 32'h1111_1111;
        @(negedge clk);
        dev_ack = '0;
        chk("R7 foreign ack ignored done", 64'(done), 64'(0));
        chk("R7 foreign ack still req", 64'(dev_req), 64'(1));
        dev_rdata[0 +: XLEN] = 32'h2222_2222;
        dev_ack[0] = 1'b1;
        @(negedge clk);
        dev_ack = '0;
        chk("R7 own ack rd", 64'(rd), 64'h2222_2222);
        chk("R7 own ack done", 64'(done), 64'(1));
    endtask

    task automatic t_cfg_err;
        ext_op("R8 device cfg err", 3'd6, 32'h0000_0020, 32'h0, 2'd0, 0,
               15'h6000, 1, 32'hFFFF_0000, 1'b1);
    endtask

    task automatic t_busy_ignore;
        send(3'd0, 32'h0000_0020, 32'h0, 2'd0);
        @(negedge clk);
        op_valid = 1'b1; op_rs1 = 32'h0000_0001; op_priv = 2'd0;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 ready low", 64'(op_ready), 64'(0));
        chk("R9 no result while busy", 64'(done), 64'(0));
        dev_rdata[0 +: XLEN] = 32'h4444_5555;
        dev_ack[0] = 1'b1;
        @(negedge clk);
        dev_ack = '0;
        chk("R9 rd from device", 64'(rd), 64'h4444_5555);
        @(negedge clk);
        chk("R9 ignored op gave no result", 64'(done), 64'(0));
    endtask

    task automatic t_remove;
        cfg(3, 1'b0, 12'd32, 2'd0, 2'd1, 12'd0);
        send(3'd0, 32'h0000_0020, 32'h0, 2'd0);
        expect_trap("R10 removed entry", 1'b0);
        cfg(3, 1'b1, 12'd32, 2'd0, 2'd0, 12'd1);
        send(3'd0, 32'h0000_0020, 32'h0, 2'd0);
        chk("R10 rewritten rd", 64'(rd), 64'hFFFF_FFFF);
        chk("R10 rewritten trap", 64'(trap), 64'(0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nerr++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_fallback();
        t_lun0();
        t_priv_miss();
        t_external();
        t_other_ack();
        t_cfg_err();
        t_busy_ignore();
        t_remove();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule